// File: doc/BRIEF.md
# Static Port-Merge Configuration Controller

This block fixes the pairing of the wide ports of a 16-port switch front end at fundamental reset. The switch has six x4 ports (0 to 5) and ten x1 ports (6 to 15). Port 0 is the upstream port. All other ports are downstream. Each pair of x4 ports, an even port n and port n+1, has a merge strap. When the strap of a pair is seen at the end of fundamental reset, the two ports act as one x8 port that keeps the number n. The odd port then drops off the virtual bus.

The strap inputs go through a two-flop synchronizer. The synchronized value is followed on every clock while the active-low fundamental reset is asserted and is frozen from the edge where reset is released. The frozen pairing is applied in these ways:
- The odd port's outputs are held at 0, which is their negated level.
- The odd port's inputs are masked to 0.
- The odd port's four lanes are handed to the even port.
- The link-width defaults are set for both ports of the pair.
- Configuration requests addressed to the odd port's device number are flagged as unsupported requests.
- A presence vector and a port count are exported, so that management accesses to a removed port can be blocked.

Top module: `port_merge_ctrl`

## Requirements
- R1: Port 0 is always present. Its inputs and outputs always pass through unchanged, and a configuration request to device 0 is never flagged as unsupported.
- R2: The pairing follows the synchronized straps only while `fund_rst_n` is low. After release, strap changes have no effect on any output until the next fundamental reset.
- R3: For a merged pair with odd port k, every bit of `port_out[k*OUT_W +: OUT_W]` is 0. For every present port, `port_out` equals `port_out_raw`.
- R4: For a merged pair with odd port k, every bit of `port_in[k*IN_W +: IN_W]` is 0. For every present port, `port_in` equals `port_in_raw`.
- R5: `cfg_ur` is 1 exactly when `cfg_valid` is 1 and `cfg_dev` names a port that is not present.
- R6: The field `lane_owner[l*4 +: 4]` gives the owning port of lane l (0 to 23). The owner is l/4. When that port is odd and its pair is merged, the owner is l/4-1, so the odd port's lanes become lanes 4 to 7 of the even port.
- R7: The field `max_link_width[x*6 +: 6]` gives the default width of x4 port x:
  - 6'b001000 for the even port of a merged pair;
  - 6'b000000 for the odd port of a merged pair;
  - 6'b000100 for every port of an unmerged pair.
- R8: Bit p of `port_present` is 0 only for an odd port of a merged pair, so ports 6 to 15 are always present. `port_count` equals 16 minus the number of merged pairs; with all three pairs merged it is 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| fund_rst_n | input | 1 | Fundamental reset, active low, sampled synchronously |
| merge_strap | input | 3 | Merge strap per pair; bit i covers ports 2i and 2i+1 |
| port_out_raw | input | 48 | Per-port outputs from the port logic, 3 bits per port |
| port_out | output | 48 | Per-port outputs after gating |
| port_in_raw | input | 48 | Per-port inputs from the pins, 3 bits per port |
| port_in | output | 48 | Per-port inputs after masking |
| cfg_valid | input | 1 | Configuration request on the virtual bus |
| cfg_dev | input | 4 | Target device number |
| cfg_ur | output | 1 | Request is an unsupported request |
| lane_owner | output | 96 | Owning port per lane, 4 bits per lane, 24 lanes |
| max_link_width | output | 36 | Default link width per x4 port, 6 bits each |
| port_present | output | 16 | One bit per port, 1 when on the bus |
| port_count | output | 5 | Number of ports on the bus |

## Verification
The bench covers the main strap patterns, each through its own fundamental reset:
- All pairs unmerged, which gives the plain x4 mapping.
- All pairs merged, which gives the 13-port case.
- Single pairs and mixed patterns such as 101 and 010, which show that each strap bit controls only its own pair.
- A pattern that merges the upstream pair.

After each reset release the bench toggles the straps and drives random port traffic and configuration requests. A design that keeps sampling the straps after release then diverges from the reference model. A design that gates the wrong port, or fails to gate a port, diverges as well.

// File: rtl/port_merge_ctrl.sv
module port_merge_ctrl #(
  parameter int NUM_PORTS = 16,
  parameter int NUM_X4    = 6,
  parameter int LPX       = 4,
  parameter int OUT_W     = 3,
  parameter int IN_W      = 3,
  localparam int NPAIR    = NUM_X4 / 2,
  localparam int PW       = $clog2(NUM_PORTS),
  localparam int NLANE    = NUM_X4 * LPX,
  localparam int LW       = 6
) (
  input  logic                        clk,
  input  logic                        fund_rst_n,
  input  logic [NPAIR-1:0]            merge_strap,
  input  logic [NUM_PORTS*OUT_W-1:0]  port_out_raw,
  output logic [NUM_PORTS*OUT_W-1:0]  port_out,
  input  logic [NUM_PORTS*IN_W-1:0]   port_in_raw,
  output logic [NUM_PORTS*IN_W-1:0]   port_in,
  input  logic                        cfg_valid,
  input  logic [PW-1:0]               cfg_dev,
  output logic                        cfg_ur,
  output logic [NLANE*PW-1:0]         lane_owner,
  output logic [NUM_X4*LW-1:0]        max_link_width,
  output logic [NUM_PORTS-1:0]        port_present,
  output logic [PW:0]                 port_count
);

  logic [NPAIR-1:0] strap_s1, strap_s2, merged;
  logic [NUM_PORTS-1:0] gone;

  always_ff @(posedge clk) begin
    strap_s1 <= merge_strap;
    strap_s2 <= strap_s1;
    if (!fund_rst_n) merged <= strap_s2;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    if ((p % 2 == 1) && (p < NUM_X4)) begin : g_odd
      assign gone[p] = merged[p/2];
    end else begin : g_fixed
      assign gone[p] = 1'b0;
    end
    assign port_out[p*OUT_W +: OUT_W] = gone[p] ? '0 : port_out_raw[p*OUT_W +: OUT_W];
    assign port_in[p*IN_W +: IN_W]    = gone[p] ? '0 : port_in_raw[p*IN_W +: IN_W];
  end

  assign port_present = ~gone;
  assign cfg_ur       = cfg_valid & gone[cfg_dev];

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    localparam int P = l / LPX;
    if (P % 2 == 1) begin : g_odd
      assign lane_owner[l*PW +: PW] = merged[P/2] ? PW'(P - 1) : PW'(P);
    end else begin : g_even
      assign lane_owner[l*PW +: PW] = PW'(P);
    end
  end

  for (genvar x = 0; x < NUM_X4; x++) begin : g_width
    if (x % 2 == 0) begin : g_even
      assign max_link_width[x*LW +: LW] = merged[x/2] ? LW'(2*LPX) : LW'(LPX);
    end else begin : g_odd
      assign max_link_width[x*LW +: LW] = merged[x/2] ? '0 : LW'(LPX);
    end
  end

  always_comb begin
    port_count = (PW+1)'(NUM_PORTS);
    for (int i = 0; i < NPAIR; i++)
      port_count = port_count - (PW+1)'(merged[i]);
  end

endmodule

module port_merge_ctrl_chk #(
  parameter int NUM_PORTS = 16,
  parameter int NUM_X4    = 6,
  parameter int OUT_W     = 3,
  parameter int PW        = 4,
  parameter int LW        = 6
) (
  input logic                       clk,
  input logic                       fund_rst_n,
  input logic [NUM_PORTS*OUT_W-1:0] port_out,
  input logic                       cfg_valid,
  input logic [PW-1:0]              cfg_dev,
  input logic                       cfg_ur,
  input logic [NUM_X4*LW-1:0]       max_link_width,
  input logic [NUM_PORTS-1:0]       port_present,
  input logic [PW:0]                port_count
);

  p_upstream_present_r1: assert property (@(posedge clk) disable iff (!fund_rst_n)
    port_present[0] && !(cfg_valid && cfg_dev == '0 && cfg_ur));

  p_frozen_after_release_r2: assert property (@(posedge clk) disable iff (!fund_rst_n)
    $past(fund_rst_n) |-> $stable(port_present) && $stable(max_link_width));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_quiet
    p_removed_port_quiet_r3: assert property (@(posedge clk) disable iff (!fund_rst_n)
      !port_present[p] |-> port_out[p*OUT_W +: OUT_W] == '0);
  end

  p_ur_on_missing_dev_r5: assert property (@(posedge clk) disable iff (!fund_rst_n)
    cfg_ur == (cfg_valid && !port_present[cfg_dev]));

  for (genvar x = 0; x < NUM_X4; x++) begin : g_w
    p_width_onehot_r7: assert property (@(posedge clk) disable iff (!fund_rst_n)
      $onehot0(max_link_width[x*LW +: LW]));
  end

  p_count_matches_present_r8: assert property (@(posedge clk) disable iff (!fund_rst_n)
    int'(port_count) == $countones(port_present));

endmodule

bind port_merge_ctrl port_merge_ctrl_chk #(
  .NUM_PORTS(NUM_PORTS), .NUM_X4(NUM_X4), .OUT_W(OUT_W), .PW(PW), .LW(LW)
) u_chk (
  .clk(clk), .fund_rst_n(fund_rst_n), .port_out(port_out),
  .cfg_valid(cfg_valid), .cfg_dev(cfg_dev), .cfg_ur(cfg_ur),
  .max_link_width(max_link_width), .port_present(port_present),
  .port_count(port_count)
);

// File: tb/port_merge_ctrl_test.sv
module port_merge_ctrl_test;
  logic clk = 0;
  always #5 clk = ~clk;

  logic        fund_rst_n;
  logic [2:0]  merge_strap;
  logic [47:0] port_out_raw, port_out, port_in_raw, port_in;
  logic        cfg_valid, cfg_ur;
  logic [3:0]  cfg_dev;
  logic [95:0] lane_owner;
  logic [35:0] max_link_width;
  logic [15:0] port_present;
  logic [4:0]  port_count;

  port_merge_ctrl uut (.*);

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [2:0] exp_m;

  task automatic chk(string req, string what, logic [95:0] act, logic [95:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit removed(int p);
    return (p % 2 == 1) && (p < 6) && exp_m[p/2];
  endfunction

  task automatic compare_all();
    logic [47:0] eo, ei;
    logic [95:0] el;
    logic [35:0] ew;
    logic [15:0] ep;
    int n = 16;
    for (int p = 0; p < 16; p++) begin
      ep[p] = !removed(p);
      eo[p*3 +: 3] = removed(p) ? 3'b0 : port_out_raw[p*3 +: 3];
      ei[p*3 +: 3] = removed(p) ? 3'b0 : port_in_raw[p*3 +: 3];
      if (removed(p)) n--;
    end
    for (int l = 0; l < 24; l++) begin
      int o = l / 4;
      if (removed(o)) o = o - 1;
      el[l*4 +: 4] = 4'(o);
    end
    for (int x = 0; x < 6; x++)
      ew[x*6 +: 6] = exp_m[x/2] ? ((x % 2 == 0) ? 6'b001000 : 6'b000000) : 6'b000100;
    chk("R1", "upstream", {port_present[0], port_out[2:0], port_in[2:0]},
        {1'b1, port_out_raw[2:0], port_in_raw[2:0]});
    chk("R3", "port_out", port_out, eo);
    chk("R4", "port_in", port_in, ei);
    chk("R5", "cfg_ur", cfg_ur, cfg_valid && removed(int'(cfg_dev)));
    chk("R6", "lane_owner", lane_owner, el);
    chk("R7", "max_link_width", max_link_width, ew);
    chk("R8", "port_present", port_present, ep);
    chk("R8", "port_count", port_count, n);
  endtask

  task automatic drive_random();
    port_out_raw = {$urandom, $urandom};
    port_in_raw  = {$urandom, $urandom};
    cfg_valid    = 1'($urandom);
    cfg_dev      = 4'($urandom);
  endtask

  task automatic run_config(logic [2:0] s);
    merge_strap = s;
    exp_m = s;
    fund_rst_n = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 4) compare_all();
      drive_random();
    end
    fund_rst_n = 1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      compare_all();
      if (i % 5 == 2) merge_strap = 3'($urandom); // R2: no effect after release
      drive_random();
    end
    if (s == 3'b111) chk("R8", "13-port count", port_count, 13);
  endtask

  initial begin
    fund_rst_n = 0;
    merge_strap = 0;
    drive_random();
    run_config(3'b000);
    run_config(3'b111);
    run_config(3'b101);
    run_config(3'b010);
    run_config(3'b001);
    run_config(3'b100);
    run_config(3'b011);
    run_config(3'b000);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule